// File: doc/BRIEF.md
# Two-Counter Event Performance Monitor

This block counts hardware events on two general-purpose counters. Each counter pairs with a 32-bit event-select register that names an event code, a unit mask that qualifies it, and optional threshold, invert and edge-detect controls. A set of event inputs arrives every cycle, each carrying an 8-bit code and an 8-bit qualifier. A counter adds either the number of matching inputs in that cycle or one count per cycle that passes its threshold test.

Counting starts and stops for both counters together. A single enable bit exists, and only the copy in select register 0 takes effect. Software idles one counter by programming it with a code and mask pair that never matches. Counters are 40 bits wide, but the upper byte always follows bit 31. Software therefore preloads a negated 32-bit period and receives a sticky overflow flag and a level interrupt when the low 32 bits carry out. All registers are reached through a small register port with a registered read path.

Top module: `evmon_top`

## Requirements
- R1: An input matches a select when its code equals select bits 7:0 and its qualifier ANDed with select bits 15:8 is non-zero. With select bits 31:24 at zero, the counter adds the number of matching inputs each enabled cycle.
- R2: Bit 22 of select register 0 enables both counters. When it is clear neither counter changes. Bit 22 of select register 1 has no effect.
- R3: A write of a 32-bit value to a counter loads bits 39:32 with copies of bit 31. Bits 39:32 always equal bit 31, including after increments.
- R4: Codes 0x10, 0x14 and 0xC1 count only on counter 0. Codes 0x11, 0x12 and 0x13 count only on counter 1. A counter programmed with a code reserved for the other counter does not increment.
- R5: Code 0x2E with a unit mask of zero never increments its counter, even while the global enable is set.
- R6: With a non-zero threshold in bits 31:24, the counter adds 1 in each cycle where the match count is at least the threshold. If bit 23 (invert) is set, it adds 1 when the match count is below the threshold instead.
- R7: With bit 18 (edge) set, the counter adds 1 only in a cycle where the per-cycle condition rises from 0 to 1. The condition is the threshold test, or "any match" when the threshold is zero.
- R8: When the low 32 bits of counter i carry out, status bit i (address 4) sets and the output irq goes high. Both stay set until software writes 1 to that status bit.
- R9: The register map is 0 = select 0, 1 = select 1, 2 = counter 0, 3 = counter 1 and 4 = status. Read data is registered and valid one clock after the address is presented.
- R10: After reset, all selects, counters and status bits are zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 40 | Registered read data |
| ev_code | input | 32 | Event codes, 8 bits per input, input 0 in bits 7:0 |
| ev_qual | input | 32 | Event qualifiers, 8 bits per input |
| irq | output | 1 | Level overflow interrupt |

## Verification
The hardest states to reach from the ports are overflow and the crossing of bit 31, since counting up from zero would take billions of cycles. The stimulus reaches both by preloading a counter through the register port with a value a few counts short of the boundary, then enabling a short burst of matching events. Edge and threshold behaviour depend on how the enable timing lines up with the events. The bench therefore writes select 0 in the same cycle the events appear and clears it one cycle before they stop, so that exactly N cycles are counted and the edge history starts from a known zero.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int NUM_CNT = 2;
  localparam int SEL_W   = 32;

  typedef struct packed {
    logic [7:0] cmask;
    logic       inv;
    logic       en;
    logic [1:0] rsv_hi;
    logic       pin_ctl;
    logic       edge_det;
    logic [1:0] rsv_lo;
    logic [7:0] umask;
    logic [7:0] code;
  } sel_t;

  // counter placement: bit i set means counter i may count the code
  function automatic logic [NUM_CNT-1:0] home_mask(input logic [7:0] c);
    case (c)
      8'h10, 8'h14, 8'hC1: home_mask = 2'b01;
      8'h11, 8'h12, 8'h13: home_mask = 2'b10;
      default:             home_mask = 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/evmon_match.sv
module evmon_match #(
  parameter int NUM_EV = 4,
  parameter int CODE_W = 8,
  parameter int QUAL_W = 8,
  localparam int OCC_W = $clog2(NUM_EV + 1)
) (
  input  logic [CODE_W-1:0]        sel_code,
  input  logic [QUAL_W-1:0]        sel_umask,
  input  logic [NUM_EV*CODE_W-1:0] ev_code,
  input  logic [NUM_EV*QUAL_W-1:0] ev_qual,
  output logic [OCC_W-1:0]         occ
);
  logic [NUM_EV-1:0] hit;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    assign hit[g] = (ev_code[g*CODE_W +: CODE_W] == sel_code) &&
                    ((ev_qual[g*QUAL_W +: QUAL_W] & sel_umask) != '0);
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < NUM_EV; i++)
      occ = occ + OCC_W'(hit[i]);
  end
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int IDX   = 0,
  parameter int CNT_W = 40,
  parameter int EFF_W = 32,
  parameter int OCC_W = 3,
  localparam int EXT_W = CNT_W - EFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       code,
  input  logic [7:0]       cmask,
  input  logic             inv,
  input  logic             edge_det,
  input  logic             glob_en,
  input  logic [OCC_W-1:0] occ,
  input  logic             wr_en,
  input  logic [EFF_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_pulse
);
  import evmon_pkg::*;

  logic [NUM_CNT-1:0] mask;
  logic               allowed, active, cond, prev_q;
  logic [7:0]         occ8;
  logic [OCC_W-1:0]   step;
  logic [EFF_W:0]     sum;

  assign mask    = home_mask(code);
  assign allowed = mask[IDX];
  assign active  = glob_en && allowed;
  assign occ8    = 8'(occ);

  always_comb begin
    if (cmask == '0) cond = (occ != '0);
    else if (inv)    cond = (occ8 < cmask);
    else             cond = (occ8 >= cmask);

    if (edge_det)            step = OCC_W'(cond && !prev_q);
    else if (cmask == '0)    step = occ;
    else                     step = OCC_W'(cond);
  end

  assign sum       = {1'b0, cnt_q[EFF_W-1:0]} + (EFF_W+1)'(step);
  assign ovf_pulse = active && !wr_en && sum[EFF_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= cond;
      if (wr_en)
        cnt_q <= {{EXT_W{wr_data[EFF_W-1]}}, wr_data};
      else if (active)
        cnt_q <= {{EXT_W{sum[EFF_W-1]}}, sum[EFF_W-1:0]};
    end
  end

  // R3
  sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q[CNT_W-1:EFF_W] == {EXT_W{cnt_q[EFF_W-1]}});

  // R2
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!glob_en && !wr_en) |=> $stable(cnt_q));

  // R4
  placement_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!allowed && !wr_en) |=> $stable(cnt_q));

  // R7
  edge_step_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_det && !wr_en) |=>
      (EFF_W'(cnt_q[EFF_W-1:0] - $past(cnt_q[EFF_W-1:0])) <= EFF_W'(1)));
endmodule

// File: rtl/evmon_top.sv
module evmon_top #(
  parameter int NUM_EV = 4,
  parameter int CODE_W = 8,
  parameter int QUAL_W = 8,
  parameter int CNT_W  = 40,
  parameter int EFF_W  = 32,
  localparam int NCNT   = evmon_pkg::NUM_CNT,
  localparam int ADDR_W = $clog2(2*NCNT + 1),
  localparam int OCC_W  = $clog2(NUM_EV + 1),
  localparam int STAT_A = 2*NCNT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [CNT_W-1:0]         reg_rdata,
  input  logic [NUM_EV*CODE_W-1:0] ev_code,
  input  logic [NUM_EV*QUAL_W-1:0] ev_qual,
  output logic                     irq
);
  import evmon_pkg::*;

  sel_t              sel_q [NCNT];
  logic [CNT_W-1:0]  cnt   [NCNT];
  logic [NCNT-1:0]   ovf_set, ovf_clr, ovf_q, ovf_nx;
  logic              glob_en;

  assign glob_en = sel_q[0].en;

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic [OCC_W-1:0] occ;
    logic             wr_cnt;

    always_ff @(posedge clk) begin
      if (rst)
        sel_q[g] <= '0;
      else if (reg_we && reg_addr == ADDR_W'(g))
        sel_q[g] <= sel_t'(reg_wdata);
    end

    assign wr_cnt = reg_we && (reg_addr == ADDR_W'(NCNT + g));

    evmon_match #(.NUM_EV(NUM_EV), .CODE_W(CODE_W), .QUAL_W(QUAL_W)) match_i (
      .sel_code (sel_q[g].code),
      .sel_umask(sel_q[g].umask),
      .ev_code  (ev_code),
      .ev_qual  (ev_qual),
      .occ      (occ)
    );

    evmon_counter #(.IDX(g), .CNT_W(CNT_W), .EFF_W(EFF_W), .OCC_W(OCC_W)) cnt_i (
      .clk      (clk),
      .rst      (rst),
      .code     (sel_q[g].code),
      .cmask    (sel_q[g].cmask),
      .inv      (sel_q[g].inv),
      .edge_det (sel_q[g].edge_det),
      .glob_en  (glob_en),
      .occ      (occ),
      .wr_en    (wr_cnt),
      .wr_data  (reg_wdata[EFF_W-1:0]),
      .cnt_q    (cnt[g]),
      .ovf_pulse(ovf_set[g])
    );

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (ovf_q[g] && !(reg_we && reg_addr == ADDR_W'(STAT_A) && reg_wdata[g]))
        |=> ovf_q[g]);
  end

  assign ovf_clr = (reg_we && reg_addr == ADDR_W'(STAT_A)) ? reg_wdata[NCNT-1:0] : '0;
  assign ovf_nx  = (ovf_q & ~ovf_clr) | ovf_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= '0;
      irq   <= 1'b0;
    end else begin
      ovf_q <= ovf_nx;
      irq   <= |ovf_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      for (int i = 0; i < NCNT; i++) begin
        if (reg_addr == ADDR_W'(i))        reg_rdata <= CNT_W'(sel_q[i]);
        if (reg_addr == ADDR_W'(NCNT + i)) reg_rdata <= cnt[i];
      end
      if (reg_addr == ADDR_W'(STAT_A)) reg_rdata <= CNT_W'(ovf_q);
    end
  end

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ovf_q != '0));

  // R10
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (ovf_q == '0 && !irq && reg_rdata == '0));
endmodule

// File: tb/evmon_top_tb_top.sv
module evmon_top_tb_top;
  localparam logic [31:0] EN   = 32'h0040_0000;
  localparam logic [31:0] EDGE = 32'h0004_0000;
  localparam logic [31:0] INV  = 32'h0080_0000;
  localparam int NVEC = 9;
  localparam int NCYC = 5;

  typedef struct packed {
    logic [15:0] tag;
    logic [31:0] s0, s1, codes, quals, e0, e1;
  } vec_t;

  localparam vec_t TBL [NVEC] = '{
    '{"R1", EN | 32'h0179,  32'h01C0,      32'h0079C079, 32'h00020101, 32'd5,  32'd5},
    '{"R1", EN | 32'hFF2E,  32'h032E,      32'h2E2E2E2E, 32'h08040201, 32'd20, 32'd10},
    '{"R2", 32'hFF2E,       EN | 32'hFF2E, 32'h2E2E2E2E, 32'h08040201, 32'd0,  32'd0},
    '{"R4", EN | 32'hFF11,  32'hFF11,      32'h11111111, 32'h01010101, 32'd0,  32'd20},
    '{"R4", EN | 32'hFF10,  32'hFF14,      32'h14141010, 32'h01010101, 32'd10, 32'd0},
    '{"R5", EN | 32'h002E,  32'hFF2E,      32'h2E2E2E2E, 32'h0F0F0F0F, 32'd0,  32'd20},
    '{"R6", EN | 32'h0300FF2E, INV | 32'h0300FF2E, 32'h2E2E2E2E, 32'h01010101, 32'd5, 32'd0},
    '{"R6", EN | 32'h0300FF2E, INV | 32'h0300FF2E, 32'h00002E2E, 32'h01010101, 32'd0, 32'd5},
    '{"R7", EN | EDGE | 32'h0100FF2E, EDGE | INV | 32'h0100FF2E, 32'h2E2E2E2E, 32'h01010101, 32'd1, 32'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [39:0] reg_rdata;
  logic [31:0] ev_code = '0;
  logic [31:0] ev_qual = '0;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evmon_top dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_code(ev_code), .ev_qual(ev_qual), .irq(irq)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [39:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // enable with events present, count exactly n edges, then disable
  task automatic burst(input logic [31:0] s0, input logic [31:0] c,
                       input logic [31:0] q, input int n);
    @(negedge clk);
    ev_code = c; ev_qual = q;
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = s0;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (n - 1) @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0;
    @(negedge clk);
    reg_we = 1'b0; ev_code = '0; ev_qual = '0;
  endtask

  initial begin
    logic [39:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    rd(3'd0, d); chk("R10 sel0", d, 40'h0);
    rd(3'd2, d); chk("R10 cnt0", d, 40'h0);
    rd(3'd3, d); chk("R10 cnt1", d, 40'h0);
    rd(3'd4, d); chk("R10 status", d, 40'h0);
    chk("R10 irq", 40'(irq), 40'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h0);
      wr(3'd3, 32'h0);
      wr(3'd1, TBL[i].s1);
      burst(TBL[i].s0, TBL[i].codes, TBL[i].quals, NCYC);
      rd(3'd2, d); chk({string'(TBL[i].tag), " cnt0"}, d, 40'(TBL[i].e0));
      rd(3'd3, d); chk({string'(TBL[i].tag), " cnt1"}, d, 40'(TBL[i].e1));
    end

    // R9 register map readback
    wr(3'd1, 32'h1234_5678);
    rd(3'd1, d); chk("R9 sel1 readback", d, 40'h00_1234_5678);

    // R3 sign extension on write
    wr(3'd2, 32'h8000_0000);
    rd(3'd2, d); chk("R3 neg write", d, 40'hFF_8000_0000);
    wr(3'd3, 32'h7FFF_FFFF);
    rd(3'd3, d); chk("R3 pos write", d, 40'h00_7FFF_FFFF);

    // R3 increment across bit 31 without overflow
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h7FFF_FFFF);
    burst(EN | 32'hFF2E, 32'h0000_002E, 32'h0000_0001, 1);
    rd(3'd2, d); chk("R3 cross bit31", d, 40'hFF_8000_0000);
    rd(3'd4, d); chk("R8 no overflow", d, 40'h0);

    // R8 overflow on counter 0
    wr(3'd2, 32'hFFFF_FFFE);
    burst(EN | 32'hFF2E, 32'h0000_002E, 32'h0000_0001, 2);
    rd(3'd2, d); chk("R8 wrap cnt0", d, 40'h0);
    rd(3'd4, d); chk("R8 status0", d, 40'h1);
    chk("R8 irq set", 40'(irq), 40'h1);
    wr(3'd4, 32'h1);
    chk("R8 irq cleared", 40'(irq), 40'h0);
    rd(3'd4, d); chk("R8 status cleared", d, 40'h0);

    // R8 overflow on counter 1 with a multi-count step
    wr(3'd3, 32'hFFFF_FFFE);
    wr(3'd1, 32'hFF2E);
    burst(EN | 32'h002E, 32'h2E2E_2E2E, 32'h0101_0101, 1);
    rd(3'd3, d); chk("R8 wrap cnt1", d, 40'h2);
    rd(3'd4, d); chk("R8 status1", d, 40'h2);
    chk("R8 irq set 1", 40'(irq), 40'h1);
    wr(3'd4, 32'h2);
    chk("R8 irq cleared 1", 40'(irq), 40'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule